// File: doc/BRIEF.md
# Floating-Point Control Register with Accuracy-Mode Resolver

This block holds the floating-point control and status word. The word carries the sticky exception flags, the dynamic rounding mode and a three-bit accuracy mode. The accuracy mode sets the minimum accuracy that floating-point results must meet. Operand and result formats do not change, and a result that is more accurate than requested is always allowed. Software changes the word with write, set and clear accesses. The floating-point units feed newly raised exception flags back into it.

For each issued floating-point instruction, the block takes the instruction's rounding-mode field and its operation class. It returns, in the same cycle, the effective rounding mode, the effective accuracy mode and an illegal-instruction request. The request fires when a dynamic rounding mode is invalid, or when the current accuracy mode has no hardware support for that class, so that software can emulate the operation. A per-class bitmask parameter decides which pairs of accuracy mode and class the hardware supports.

Top module: `fp_ctrl_csr`

## Requirements
- R1: After reset, `csr_rdata` reads 0, which gives accuracy mode 000 (correctly rounded), rounding mode 000 and no flags.
- R2: `csr_op`=01 (write) replaces the stored word with `csr_wdata[10:0]`. The layout is flags in bits 4:0, rounding mode in bits 7:5 and accuracy mode in bits 10:8. Bits 31:11 ignore writes and always read 0.
- R3: `csr_op`=10 (set) ORs `csr_wdata[10:0]` into the word. `csr_op`=11 (clear) clears every word bit that is 1 in `csr_wdata[10:0]`. `csr_op`=00 is no access.
- R4: On a cycle with `csr_op`=00 and `flag_valid`=1, `flag_in` is ORed into bits 4:0. Flags are never removed except by a CSR access.
- R5: When a write, set or clear happens in the same cycle as `flag_valid`, the CSR result is stored and that cycle's `flag_in` is discarded.
- R6: An instruction rounding-mode field other than 111 appears unchanged on `eff_rm`. The value 111 selects the stored rounding mode (bits 7:5).
- R7: With `insn_valid`=1, `insn_rm`=111 and a stored rounding mode of 101, 110 or 111, `illegal` is 1. A static rounding field never traps by itself.
- R8: The defined accuracy encodings are 000 (IEEE), 010 (under 1 ULP), 100 (graphics accuracy) and 110 (approximate). With the default parameter, class 0 supports all four, class 1 only 000, class 2 supports 000 and 010, and class 3 supports 000, 010 and 100. A valid instruction whose pair is unsupported raises `illegal`.
- R9: The accuracy encodings 001, 011, 101 and 111 are stored as written but are unsupported for every class, so any valid instruction raises `illegal`.
- R10: `eff_rm`, `eff_acc` and `illegal` are combinational and use the stored word as it was before any CSR access in the same cycle. `eff_acc` equals the stored bits 10:8.
- R11: With `insn_valid`=0, `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_op | input | 2 | 00 none, 01 write, 10 set, 11 clear |
| csr_wdata | input | 32 | CSR access operand |
| csr_rdata | output | 32 | Current register word |
| flag_valid | input | 1 | Exception flags from the FPU are valid |
| flag_in | input | 5 | Exception flags to accrue |
| insn_valid | input | 1 | A floating-point instruction is being resolved |
| insn_rm | input | 3 | Instruction rounding-mode field |
| insn_class | input | CLASS_W | Operation class of the instruction |
| eff_rm | output | 3 | Effective rounding mode |
| eff_acc | output | 3 | Effective accuracy mode |
| illegal | output | 1 | Illegal-instruction trap request |

## Verification
The assertions assume that `csr_op`, `csr_wdata`, `flag_valid` and `flag_in` are settled before each rising edge. They also assume that `insn_class` stays below the number of classes whenever `insn_valid` is high. The bench drives every input shortly after the falling edge and uses only classes 0 to 3. It also holds `insn_valid` low in the vectors that check R11, so that an invalid stored rounding mode cannot be mistaken for a real trap.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int FLAG_W = 5;
    localparam int RM_W   = 3;
    localparam int ACC_W  = 3;
    localparam int WORD_W = FLAG_W + RM_W + ACC_W;
    localparam int CSR_W  = 32;
    localparam int ACC_N  = 1 << ACC_W;

    localparam logic [RM_W-1:0]  RM_DYNAMIC = 3'b111;
    localparam logic [RM_W-1:0]  RM_MAX_OK  = 3'b100;
    localparam logic [ACC_N-1:0] ACC_LISTED = 8'b0101_0101;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [RM_W-1:0]   frm;
        logic [FLAG_W-1:0] flags;
    } fpword_t;

    typedef struct packed {
        fpword_t word;
    } fpc_state_t;

endpackage

// File: rtl/fpc_state.sv
module fpc_state
    import fpc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           op,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 flag_valid,
    input  logic [FLAG_W-1:0]    flag_in,
    output fpword_t              word
);

    fpc_state_t state_d, state_q;
    csr_op_e    op_e;

    always_comb begin
        op_e    = csr_op_e'(op);
        state_d = state_q;
        unique case (op_e)
            OP_WRITE: state_d.word = fpword_t'(wdata);
            OP_SET:   state_d.word = fpword_t'(WORD_W'(state_q.word) | wdata);
            OP_CLEAR: state_d.word = fpword_t'(WORD_W'(state_q.word) & ~wdata);
            default: begin
                if (flag_valid) begin
                    state_d.word.flags = state_q.word.flags | flag_in;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign word = state_q.word;

endmodule

// File: rtl/fpc_support.sv
module fpc_support
    import fpc_pkg::*;
#(
    parameter int                        NUM_CLASSES = 4,
    parameter int                        CLASS_W     = 2,
    parameter logic [NUM_CLASSES*ACC_N-1:0] SUPPORT  = '1
) (
    input  logic [CLASS_W-1:0] cls,
    input  logic [ACC_W-1:0]   acc,
    output logic               ok
);

    logic [ACC_N-1:0] row [NUM_CLASSES];

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_row
        assign row[g] = SUPPORT[g*ACC_N +: ACC_N] & ACC_LISTED;
    end

    always_comb begin
        ok = 1'b0;
        for (int i = 0; i < NUM_CLASSES; i++) begin
            if (cls == CLASS_W'(i)) begin
                ok = row[i][acc];
            end
        end
    end

endmodule

// File: rtl/fpc_resolve.sv
module fpc_resolve
    import fpc_pkg::*;
#(
    parameter int                        NUM_CLASSES = 4,
    parameter int                        CLASS_W     = 2,
    parameter logic [NUM_CLASSES*ACC_N-1:0] SUPPORT  = '1
) (
    input  fpword_t             word,
    input  logic                insn_valid,
    input  logic [RM_W-1:0]     insn_rm,
    input  logic [CLASS_W-1:0]  insn_class,
    output logic [RM_W-1:0]     eff_rm,
    output logic [ACC_W-1:0]    eff_acc,
    output logic                illegal
);

    logic pair_ok;
    logic dyn_sel;
    logic dyn_bad;

    fpc_support #(
        .NUM_CLASSES (NUM_CLASSES),
        .CLASS_W     (CLASS_W),
        .SUPPORT     (SUPPORT)
    ) u_support (
        .cls (insn_class),
        .acc (word.acc),
        .ok  (pair_ok)
    );

    always_comb begin
        dyn_sel = (insn_rm == RM_DYNAMIC);
        dyn_bad = dyn_sel && (word.frm > RM_MAX_OK);
        eff_rm  = dyn_sel ? word.frm : insn_rm;
        eff_acc = word.acc;
        illegal = insn_valid && (dyn_bad || !pair_ok);
    end

endmodule

// File: rtl/fp_ctrl_csr.sv
module fp_ctrl_csr
    import fpc_pkg::*;
#(
    parameter int                           NUM_CLASSES = 4,
    parameter logic [NUM_CLASSES*ACC_N-1:0] ACC_SUPPORT = 32'h15_05_01_55,
    localparam int                          CLASS_W     = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          csr_op,
    input  logic [31:0]         csr_wdata,
    output logic [31:0]         csr_rdata,
    input  logic                flag_valid,
    input  logic [4:0]          flag_in,
    input  logic                insn_valid,
    input  logic [2:0]          insn_rm,
    input  logic [CLASS_W-1:0]  insn_class,
    output logic [2:0]          eff_rm,
    output logic [2:0]          eff_acc,
    output logic                illegal
);

    fpword_t word;

    fpc_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (csr_op),
        .wdata      (csr_wdata[WORD_W-1:0]),
        .flag_valid (flag_valid),
        .flag_in    (flag_in),
        .word       (word)
    );

    fpc_resolve #(
        .NUM_CLASSES (NUM_CLASSES),
        .CLASS_W     (CLASS_W),
        .SUPPORT     (ACC_SUPPORT)
    ) u_resolve (
        .word       (word),
        .insn_valid (insn_valid),
        .insn_rm    (insn_rm),
        .insn_class (insn_class),
        .eff_rm     (eff_rm),
        .eff_acc    (eff_acc),
        .illegal    (illegal)
    );

    assign csr_rdata = {{(CSR_W-WORD_W){1'b0}}, word};

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
    parameter int CLASS_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          csr_op,
    input logic [31:0]         csr_wdata,
    input logic [31:0]         csr_rdata,
    input logic                flag_valid,
    input logic [4:0]          flag_in,
    input logic                insn_valid,
    input logic [2:0]          insn_rm,
    input logic [CLASS_W-1:0]  insn_class,
    input logic [2:0]          eff_rm,
    input logic [2:0]          eff_acc,
    input logic                illegal
);

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_op == 2'b01) |=> (csr_rdata[10:0] == $past(csr_wdata[10:0])));

    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_op == 2'b11) |=> ((csr_rdata[10:0] & $past(csr_wdata[10:0])) == 11'd0));

    a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_op == 2'b00) |=> ((csr_rdata[4:0] & $past(csr_rdata[4:0])) == $past(csr_rdata[4:0])));

    a_r4_flags_accrue: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_op == 2'b00 && flag_valid) |=>
            (csr_rdata[4:0] == ($past(csr_rdata[4:0]) | $past(flag_in))));

    a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_op == 2'b00) |=> $stable(csr_rdata[10:5]));

    a_r6_static_rm: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_rm != 3'b111) |-> (eff_rm == insn_rm));

    a_r7_bad_dynamic: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_rm == 3'b111 && csr_rdata[7:5] > 3'b100) |-> illegal);

    a_r9_unlisted_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && csr_rdata[8]) |-> illegal);

    a_r10_acc_view: assert property (@(posedge clk) disable iff (!rst_n)
        eff_acc == csr_rdata[10:8]);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |-> !illegal);

endmodule

bind fp_ctrl_csr fpc_checker #(.CLASS_W(CLASS_W)) u_fpc_checker (.*);

// File: tb/test_fp_ctrl_csr.sv
`timescale 1ns/1ps
module test_fp_ctrl_csr;

    typedef struct {
        string       tag;
        logic [31:0] rd;
        logic [2:0]  rm;
        logic [2:0]  acc;
        logic        ill;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  csr_op = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        flag_valid = 1'b0;
    logic [4:0]  flag_in = '0;
    logic        insn_valid = 1'b0;
    logic [2:0]  insn_rm = '0;
    logic [1:0]  insn_class = '0;
    logic [2:0]  eff_rm;
    logic [2:0]  eff_acc;
    logic        illegal;

    item_t       sb [$];
    logic [10:0] m_word = '0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    fp_ctrl_csr i_fp_ctrl_csr (
        .clk, .rst_n, .csr_op, .csr_wdata, .csr_rdata, .flag_valid, .flag_in,
        .insn_valid, .insn_rm, .insn_class, .eff_rm, .eff_acc, .illegal
    );

    function automatic bit supported(input logic [1:0] cls, input logic [2:0] acc);
        logic [7:0] m;
        case (cls)
            2'd0: m = 8'h55;
            2'd1: m = 8'h01;
            2'd2: m = 8'h05;
            default: m = 8'h15;
        endcase
        return (acc[0] == 1'b0) && m[acc];
    endfunction

    task automatic vec(input string tag, input logic [1:0] op, input logic [31:0] wd,
                       input logic fv, input logic [4:0] fin,
                       input logic iv, input logic [2:0] rm, input logic [1:0] cls);
        item_t it;
        @(negedge clk);
        csr_op = op; csr_wdata = wd; flag_valid = fv; flag_in = fin;
        insn_valid = iv; insn_rm = rm; insn_class = cls;
        it.tag = tag;
        it.rd  = {21'd0, m_word};
        it.rm  = (rm == 3'b111) ? m_word[7:5] : rm;
        it.acc = m_word[10:8];
        it.ill = iv && (((rm == 3'b111) && (m_word[7:5] > 3'd4)) || !supported(cls, m_word[10:8]));
        sb.push_back(it);
        case (op)
            2'b01: m_word = wd[10:0];
            2'b10: m_word = m_word | wd[10:0];
            2'b11: m_word = m_word & ~wd[10:0];
            default: if (fv) m_word[4:0] = m_word[4:0] | fin;
        endcase
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                it = sb.pop_front();
                n_vec++;
                if (csr_rdata !== it.rd || eff_rm !== it.rm || eff_acc !== it.acc || illegal !== it.ill) begin
                    n_bad++;
                    $display("FAIL %s: got rd=%h rm=%0d acc=%0d ill=%b, expected rd=%h rm=%0d acc=%0d ill=%b",
                             it.tag, csr_rdata, eff_rm, eff_acc, illegal, it.rd, it.rm, it.acc, it.ill);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        vec("R1 reset word", 2'b00, 0, 0, 0, 1, 3'b000, 2'd1);
        // R2: reserved bits ignore writes
        vec("R2 write all ones", 2'b01, 32'hFFFF_FFFF, 0, 0, 0, 3'b000, 2'd0);
        vec("R2 reserved read zero", 2'b01, 32'h0000_0000, 0, 0, 0, 3'b000, 2'd0);
        // R6: static and dynamic rounding, frm=010
        vec("R6 write frm=2", 2'b01, 32'h0000_0040, 0, 0, 0, 3'b000, 2'd0);
        vec("R6 static rm passes", 2'b00, 0, 0, 0, 1, 3'b001, 2'd1);
        vec("R6 dynamic picks frm", 2'b00, 0, 0, 0, 1, 3'b111, 2'd1);
        // R7: invalid dynamic modes 101,110,111
        for (int f = 5; f < 8; f++) begin
            vec("R7 set bad frm", 2'b01, 32'(f) << 5, 0, 0, 0, 3'b000, 2'd0);
            vec("R7 dynamic traps", 2'b00, 0, 0, 0, 1, 3'b111, 2'd0);
            vec("R7 static no trap", 2'b00, 0, 0, 0, 1, 3'b100, 2'd0);
            vec("R11 idle no trap", 2'b00, 0, 0, 0, 0, 3'b111, 2'd0);
        end
        // R8, R9: every accuracy encoding against every class
        for (int a = 0; a < 8; a++) begin
            vec("R8 write acc", 2'b01, 32'(a) << 8, 0, 0, 0, 3'b000, 2'd0);
            for (int c = 0; c < 4; c++) begin
                vec((a[0] ? "R9 unlisted acc" : "R8 acc/class pair"), 2'b00, 0, 0, 0, 1, 3'b000, 2'(c));
            end
            vec("R11 idle unsupported", 2'b00, 0, 0, 0, 0, 3'b000, 2'd1);
        end
        // R4: sticky accrual
        vec("R4 clear all", 2'b01, 0, 0, 0, 0, 3'b000, 2'd0);
        vec("R4 accrue a", 2'b00, 0, 1, 5'b00101, 0, 3'b000, 2'd0);
        vec("R4 accrue b", 2'b00, 0, 1, 5'b10000, 0, 3'b000, 2'd0);
        vec("R4 invalid flags ignored", 2'b00, 0, 0, 5'b01010, 0, 3'b000, 2'd0);
        vec("R4 sticky check", 2'b00, 0, 0, 0, 0, 3'b000, 2'd0);
        // R3: set and clear
        vec("R3 set acc+flag", 2'b10, 32'h0000_0402, 0, 0, 0, 3'b000, 2'd0);
        vec("R3 clear flags", 2'b11, 32'h0000_0014, 0, 0, 0, 3'b000, 2'd0);
        vec("R3 after clear", 2'b00, 0, 0, 0, 1, 3'b000, 2'd3);
        // R5: CSR access wins over accrual
        vec("R5 write vs flags", 2'b01, 32'h0000_0001, 1, 5'b11110, 0, 3'b000, 2'd0);
        vec("R5 set vs flags", 2'b10, 32'h0000_0002, 1, 5'b11100, 0, 3'b000, 2'd0);
        vec("R5 clear vs flags", 2'b11, 32'h0000_0001, 1, 5'b01000, 0, 3'b000, 2'd0);
        vec("R5 result", 2'b00, 0, 0, 0, 0, 3'b000, 2'd0);
        // R10: outputs use pre-write word in the access cycle
        vec("R10 write bad acc same cycle", 2'b01, 32'h0000_01E0, 0, 0, 1, 3'b111, 2'd1);
        vec("R10 new word seen", 2'b00, 0, 0, 0, 1, 3'b111, 2'd1);
        vec("R10 restore", 2'b01, 32'h0000_0620, 0, 0, 1, 3'b111, 2'd0);
        vec("R10 approx class0", 2'b00, 0, 0, 0, 1, 3'b111, 2'd0);
        @(negedge clk);
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule